// File: doc/BRIEF.md
# Single-Wire Pulse Token Transmitter

This block drives the host side of a single-wire, open-drain bus on which each bit is carried by the number of low pulses inside a fixed-length bit window. A caller asks for one of four things: a long-low wake token, a single zero token, a single one token, or a whole byte that goes out as eight bit tokens back to back. The block turns the request into timed low pulses by counting system clock cycles. Between pulses it keeps the line released.

A one token is a single short low pulse followed by a released line until the window closes. A zero token adds a released gap and a second short low pulse before the rest of the window. A wake token holds the line low for a long interval. It then keeps the line released for a recovery interval before any data token may follow. That recovery interval must stay well below the target's idle timeout. All durations are parameters in clock cycles. The defaults assume a 50 MHz clock: about 4.34 µs pulses, a 39 µs window, a 60 µs wake low and 2.5 ms of wake recovery.

The output `pull_low` feeds the enable of an external open-drain pad. `busy` covers each token or byte, and `done` marks its end with a one-cycle pulse. A new request may be issued in the same cycle as `done`.

Top module: `swire_token_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pull_low`, `busy` and `done` are all 0.
- R2: A one token (`req_kind` = 2) drives `pull_low` high for T_START cycles, starting in the cycle after acceptance. The line then stays released for the remaining T_BIT − T_START cycles of the window.
- R3: A zero token (`req_kind` = 1) is low for T_START cycles, released for T_GAP cycles and low for T_SECOND cycles. It is then released for the rest of a T_BIT-cycle window.
- R4: A wake token (`req_kind` = 0) holds the line low for T_WAKE_LO cycles and then released for T_WAKE_HI cycles. Only after that may the next token start.
- R5: A byte request (`req_kind` = 3) sends the eight bits of `req_byte` as bit tokens, bit 0 first, each in its own T_BIT-cycle window. There is no gap between windows, so the byte lasts 8·T_BIT cycles.
- R6: `busy` is 1 from the cycle after acceptance through the last cycle of the token or byte. `done` is 1 for exactly the next cycle, with `busy` 0 in that cycle.
- R7: A request made while `busy` is 1 is ignored and does not change the pulse pattern on the line.
- R8: A request made in the cycle where `done` is 1 is accepted, and its first low pulse starts in the following cycle.
- R9: `req_kind` encodes 0 = wake, 1 = zero, 2 = one, 3 = byte.
- R10: `pull_low` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_kind | input | 2 | 0 wake, 1 zero, 2 one, 3 byte |
| req_byte | input | 8 | Byte sent LSB first for kind 3 |
| pull_low | output | 1 | 1 pulls the bus low through the pad |
| busy | output | 1 | A token or byte is in progress |
| done | output | 1 | One-cycle pulse after each token or byte |

## Verification
Two events can land in the same cycle: the end-of-token `done` pulse and the acceptance of the next request. The bench provokes this by issuing every follow-on request in the `done` cycle. It does so through a sweep of all 256 byte values and through a mixed chain of wake, byte, zero and one tokens. In the cycle after `done`, the bench requires the line to be low with `busy` high and `done` already back at 0. Every sample of each window is compared with a pattern the bench computes from the timing parameters, so a late start or a merged window shows up as a mismatch.

// File: rtl/swire_tx_pkg.sv
// Package: shared types and constant helpers for the single-wire token transmitter.
// Assumes: all durations are expressed in system clock cycles.
package swire_tx_pkg;

    // Request encoding at the block's edge (fixed, see R9).
    typedef enum logic [1:0] {
        TK_WAKE = 2'd0,
        TK_ZERO = 2'd1,
        TK_ONE  = 2'd2,
        TK_BYTE = 2'd3
    } tok_kind_e;

    // Segments of one token: leading low, released gap, second low, released tail.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LEAD   = 3'd1,
        PH_GAP    = 3'd2,
        PH_SECOND = 3'd3,
        PH_TAIL   = 3'd4
    } tok_phase_e;

    // Larger of two cycle counts, used to size the segment counter.
    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/swire_seg_timer.sv
// Module: down-counting segment timer.
// Loads a segment length and raises 'last' in the final cycle of that segment.
// Assumes: load_len is never zero; a load in the 'last' cycle chains segments without a gap.
module swire_seg_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_len,
    output logic          running,
    output logic          last
);

    logic [CW-1:0] cnt;

    // Count down the remaining cycles of the current segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign running = (cnt != '0);
    assign last    = (cnt == CW'(1));

    // R2 R3 R4: every segment lasts at least one cycle
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_len != '0));

    // R6: the timer is never restarted in the middle of a segment except from its last cycle
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && running) |-> last);

endmodule

// File: rtl/swire_token_seq.sv
// Module: token waveform sequencer.
// Produces the low/released segments of one wake, zero or one token using a segment timer.
// Assumes: 'start' arrives only when idle or in the token's last cycle (tok_end);
//          T_BIT_CYC > T_START_CYC + T_GAP_CYC + T_SECOND_CYC.
module swire_token_seq
    import swire_tx_pkg::*;
#(
    parameter int T_START_CYC   = 217,
    parameter int T_GAP_CYC     = 217,
    parameter int T_SECOND_CYC  = 217,
    parameter int T_BIT_CYC     = 1950,
    parameter int T_WAKE_LO_CYC = 3000,
    parameter int T_WAKE_HI_CYC = 125000,
    parameter int CW            = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_wake,
    input  logic start_bit,
    output logic pull_low,
    output logic tok_end
);

    localparam int ONE_TAIL_CYC  = T_BIT_CYC - T_START_CYC;
    localparam int ZERO_TAIL_CYC = T_BIT_CYC - T_START_CYC - T_GAP_CYC - T_SECOND_CYC;

    tok_phase_e    phase, phase_nxt;
    logic          is_wake;
    logic          bit_val;
    logic          t_load;
    logic [CW-1:0] t_len;
    logic          t_running;
    logic          t_last;

    swire_seg_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_len (t_len),
        .running  (t_running),
        .last     (t_last)
    );

    // Pick the next segment and its length when a token starts or a segment ends.
    always_comb begin
        phase_nxt = phase;
        t_load    = 1'b0;
        t_len     = '0;
        if (start) begin
            phase_nxt = PH_LEAD;
            t_load    = 1'b1;
            t_len     = start_wake ? CW'(T_WAKE_LO_CYC) : CW'(T_START_CYC);
        end else if (t_last) begin
            case (phase)
                PH_LEAD: begin
                    t_load = 1'b1;
                    if (is_wake) begin
                        phase_nxt = PH_TAIL;
                        t_len     = CW'(T_WAKE_HI_CYC);
                    end else if (bit_val) begin
                        phase_nxt = PH_TAIL;
                        t_len     = CW'(ONE_TAIL_CYC);
                    end else begin
                        phase_nxt = PH_GAP;
                        t_len     = CW'(T_GAP_CYC);
                    end
                end
                PH_GAP: begin
                    phase_nxt = PH_SECOND;
                    t_load    = 1'b1;
                    t_len     = CW'(T_SECOND_CYC);
                end
                PH_SECOND: begin
                    phase_nxt = PH_TAIL;
                    t_load    = 1'b1;
                    t_len     = CW'(ZERO_TAIL_CYC);
                end
                PH_TAIL: begin
                    phase_nxt = PH_IDLE;
                end
                default: begin
                    phase_nxt = PH_IDLE;
                end
            endcase
        end
    end

    // Hold the current segment and the attributes of the token in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            is_wake <= 1'b0;
            bit_val <= 1'b0;
        end else begin
            phase <= phase_nxt;
            if (start) begin
                is_wake <= start_wake;
                bit_val <= start_bit;
            end
        end
    end

    assign pull_low = (phase == PH_LEAD) || (phase == PH_SECOND);
    assign tok_end  = t_last && (phase == PH_TAIL);

    // Length of the current low run, used only by the width check below.
    logic [CW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (pull_low) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    // R2 R3 R4
    low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_low) |-> (low_run == CW'(T_START_CYC) || low_run == CW'(T_SECOND_CYC)
                             || low_run == CW'(T_WAKE_LO_CYC)));

    // R7
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (phase == PH_IDLE || tok_end));

    // R6: the sequencer is active exactly while its timer runs
    phase_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> t_running);

endmodule

// File: rtl/swire_frame_ctrl.sv
// Module: request and byte framing controller.
// Accepts a request when idle, splits byte requests into bit tokens (LSB first),
// starts each token in the sequencer and reports busy/done.
// Assumes: tok_end is a one-cycle pulse in the last cycle of each token.
module swire_frame_ctrl
    import swire_tx_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic [BYTE_BITS-1:0] req_byte,
    input  logic                 tok_end,
    output logic                 busy,
    output logic                 done,
    output logic                 start,
    output logic                 start_wake,
    output logic                 start_bit
);

    localparam int LW = $clog2(BYTE_BITS + 1);

    logic [BYTE_BITS-1:0] shift_q;
    logic [LW-1:0]        left_q;
    logic                 accept;
    logic                 more;

    assign accept = req_valid && !busy;
    assign more   = tok_end && (left_q != '0);

    // Start a token on acceptance or when a byte still has bits to send.
    always_comb begin
        start      = accept || more;
        start_wake = accept && (req_kind == TK_WAKE);
        if (accept) begin
            case (req_kind)
                TK_ZERO: start_bit = 1'b0;
                TK_ONE:  start_bit = 1'b1;
                TK_BYTE: start_bit = req_byte[0];
                default: start_bit = 1'b0;
            endcase
        end else begin
            start_bit = shift_q[0];
        end
    end

    // Track busy, the remaining bits of a byte and the end-of-request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            shift_q <= '0;
            left_q  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                if (req_kind == TK_BYTE) begin
                    shift_q <= req_byte >> 1;
                    left_q  <= LW'(BYTE_BITS - 1);
                end else begin
                    shift_q <= '0;
                    left_q  <= '0;
                end
            end else if (more) begin
                shift_q <= shift_q >> 1;
                left_q  <= left_q - 1'b1;
            end else if (tok_end) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R5
    byte_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_end |-> busy);

endmodule

// File: rtl/swire_token_tx.sv
// Module: top of the single-wire pulse token transmitter.
// Wires the framing controller to the token sequencer; pull_low drives an external open-drain pad.
// Assumes: durations are in clock cycles (defaults for 50 MHz) and T_WAKE_HI_CYC stays below
//          the target's idle timeout.
module swire_token_tx
    import swire_tx_pkg::*;
#(
    parameter int T_START_CYC   = 217,
    parameter int T_GAP_CYC     = 217,
    parameter int T_SECOND_CYC  = 217,
    parameter int T_BIT_CYC     = 1950,
    parameter int T_WAKE_LO_CYC = 3000,
    parameter int T_WAKE_HI_CYC = 125000,
    parameter int BYTE_BITS     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic [BYTE_BITS-1:0] req_byte,
    output logic                 pull_low,
    output logic                 busy,
    output logic                 done
);

    localparam int unsigned MAX_LEN = max_of(max_of(T_BIT_CYC, T_WAKE_LO_CYC), T_WAKE_HI_CYC);
    localparam int          CW      = $clog2(MAX_LEN + 1);

    logic tok_end;
    logic start;
    logic start_wake;
    logic start_bit;

    swire_frame_ctrl #(.BYTE_BITS(BYTE_BITS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_byte   (req_byte),
        .tok_end    (tok_end),
        .busy       (busy),
        .done       (done),
        .start      (start),
        .start_wake (start_wake),
        .start_bit  (start_bit)
    );

    swire_token_seq #(
        .T_START_CYC   (T_START_CYC),
        .T_GAP_CYC     (T_GAP_CYC),
        .T_SECOND_CYC  (T_SECOND_CYC),
        .T_BIT_CYC     (T_BIT_CYC),
        .T_WAKE_LO_CYC (T_WAKE_LO_CYC),
        .T_WAKE_HI_CYC (T_WAKE_HI_CYC),
        .CW            (CW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_wake (start_wake),
        .start_bit  (start_bit),
        .pull_low   (pull_low),
        .tok_end    (tok_end)
    );

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pull_low);

    // R8
    chain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid) |=> (busy && pull_low));

endmodule

// File: tb/swire_token_tx_bench.sv
// Bench: compares every cycle of each token window with a pattern computed from the timing parameters.
module swire_token_tx_bench;

    localparam int CLK_P    = 10;
    localparam int P_START  = 3;
    localparam int P_GAP    = 2;
    localparam int P_SECOND = 4;
    localparam int P_BIT    = 16;
    localparam int P_WLO    = 10;
    localparam int P_WHI    = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [7:0] req_byte = 8'd0;
    logic       pull_low;
    logic       busy;
    logic       done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    swire_token_tx #(
        .T_START_CYC   (P_START),
        .T_GAP_CYC     (P_GAP),
        .T_SECOND_CYC  (P_SECOND),
        .T_BIT_CYC     (P_BIT),
        .T_WAKE_LO_CYC (P_WLO),
        .T_WAKE_HI_CYC (P_WHI),
        .BYTE_BITS     (8)
    ) u_swire_token_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_byte  (req_byte),
        .pull_low  (pull_low),
        .busy      (busy),
        .done      (done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected line level of one bit window at 1-based cycle j.
    function automatic bit bit_low(input bit v, input int j);
        if (j <= P_START) return 1'b1;
        if (!v && j > P_START + P_GAP && j <= P_START + P_GAP + P_SECOND) return 1'b1;
        return 1'b0;
    endfunction

    // Expected line level at 1-based cycle k after acceptance; R9 kind encoding.
    function automatic bit exp_low(input int kind, input logic [7:0] b, input int k);
        case (kind)
            0: return (k <= P_WLO);
            1: return bit_low(1'b0, k);
            2: return bit_low(1'b1, k);
            default: return bit_low(b[(k-1)/P_BIT], (k-1)%P_BIT + 1);
        endcase
    endfunction

    function automatic int tok_len(input int kind);
        case (kind)
            0: return P_WLO + P_WHI;
            3: return 8 * P_BIT;
            default: return P_BIT;
        endcase
    endfunction

    function automatic string tag_of(input int kind);
        case (kind)
            0: return "R4/R9 wake";
            1: return "R3/R9 zero";
            2: return "R2/R9 one";
            default: return "R5/R9 byte";
        endcase
    endfunction

    // Issue a request at the current negedge and check every cycle up to and including done.
    task automatic send(input int kind, input logic [7:0] b, input bit inject, input bit chained);
        string tag;
        tag = inject ? {"R7 ", tag_of(kind)} : tag_of(kind);
        req_valid = 1'b1;
        req_kind  = kind[1:0];
        req_byte  = b;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        for (int k = 1; k <= tok_len(kind); k++) begin
            @(negedge clk);
            check(pull_low === exp_low(kind, b, k), tag, int'(pull_low), int'(exp_low(kind, b, k)));
            check(busy === 1'b1, "R6 busy in window", int'(busy), 1);
            if (k == 1) begin
                check(done === 1'b0, "R6 done lasts one cycle", int'(done), 0);
                if (chained) check(pull_low === 1'b1, "R8 chained start", int'(pull_low), 1);
            end
            if (inject && k == 2) begin
                req_valid = 1'b1;
                req_kind  = (kind == 0) ? 2'd3 : 2'd0;
                req_byte  = 8'h00;
            end
            if (inject && k == 4) req_valid = 1'b0;
        end
        @(negedge clk);
        check(done === 1'b1, "R6 done pulse", int'(done), 1);
        check(busy === 1'b0, "R6 busy cleared", int'(busy), 0);
        check(pull_low === 1'b0, "R10 released when idle", int'(pull_low), 0);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        check(done === 1'b0, "R6 done low when idle", int'(done), 0);
        check(busy === 1'b0 && pull_low === 1'b0, "R10 idle line", int'(pull_low), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pull_low === 1'b0, "R1 reset pull_low", int'(pull_low), 0);
        check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        check(done === 1'b0, "R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pull_low === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 after reset", int'(busy), 0);

        send(2, 8'h00, 1'b0, 1'b0); idle_cycle();
        send(1, 8'h00, 1'b0, 1'b0); idle_cycle();
        send(0, 8'h00, 1'b0, 1'b0); idle_cycle();
        send(2, 8'h00, 1'b1, 1'b0); idle_cycle();
        send(0, 8'h00, 1'b1, 1'b0); idle_cycle();
        send(3, 8'hA5, 1'b1, 1'b0); idle_cycle();

        for (int v = 0; v < 256; v++) begin
            send(3, 8'(v), 1'b0, v != 0);
        end
        idle_cycle();

        send(0, 8'h00, 1'b0, 1'b0);
        send(3, 8'h3C, 1'b0, 1'b1);
        send(1, 8'h00, 1'b0, 1'b1);
        send(2, 8'h00, 1'b0, 1'b1);
        send(0, 8'h00, 1'b0, 1'b1);
        idle_cycle();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        finished = 1'b1;
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule